// File: doc/BRIEF.md
# ECC SRAM Controller Control and Status Registers

This block is the software-visible register file of an on-chip SRAM controller with error-correcting code. A word-only bus reaches it with an address, a write strobe, write data and combinational read data. Eleven hardware event sources feed a sticky status group with a mask. The mask cannot be written directly. It is opened through a write-ones-to-set enable register and closed through a write-ones-to-clear disable register. A single level interrupt goes high while any unmasked status bit is set.

Corrected and uncorrectable ECC events each latch an error record: an 18-bit failing address, a 128-bit data word and a 16-bit syndrome. The record is taken from shared error-report inputs, and only the first event is kept until software clears the status bit. A 16-bit counter tallies corrected events and saturates. Writable registers drive the ECC mode bits, the error-response control bits, the fault-injection data and syndrome, and the per-bank timing fields straight onto output ports. A read-only field reports the memory size, which is fixed by a parameter.

Top module: `ecc_sram_csr`

## Requirements
- R1: After reset, status reads 0, mask reads 0x7FF, the timing register (0x60) reads 0x249 (value 1 in each 3-bit bank field at bits 0, 3, 6, 9), `irq` is 0, and the other writable registers and the counter read 0.
- R2: A one on `evt_pulse[i]` sets status bit i (register 0x4) at the next clock edge. The event wins over a bus clear of the same bit in the same cycle, and a bus write to status never sets a bit.
- R3: Writing ones to status (0x4) clears those bits, a zero leaves a bit unchanged, and bits 31:11 read 0.
- R4: The mask (0x8) ignores direct writes. Writing 0xC ORs the data into the mask and writing 0x10 clears the written bits. Both 0xC and 0x10 read 0.
- R5: `irq` is 1 exactly when status AND mask is nonzero, and it follows register changes in the cycle after the edge that made them.
- R6: An event on bit 6 (corrected) or bit 7 (uncorrectable) while that status bit is clear loads `err_addr`, `err_data` and `err_syn` into the matching record. The corrected record sits at 0x1C (address), 0x20–0x2C (data, low word first) and 0x30 (syndrome). The uncorrectable record sits at 0x34, 0x38–0x44 and 0x48. While the bit is set the record holds its value, and bus writes never change it.
- R7: The corrected-error counter (0x6C, 16 bits) adds one per cycle with `evt_pulse[6]` high. It stays at 0xFFFF once it gets there, and writing ones clears the written bits.
- R8: Read/write registers: error response at 0x0 (4 bits, drives `err_resp_ctl`), ECC mode at 0x14 (bit 0 enable, bit 1 detect-only, bit 2 inject, drives `ecc_mode`), injection data at 0x4C–0x58 (drives `inj_data`, low word first), injection syndrome at 0x5C (16 bits, drives `inj_syn`) and timing at 0x60 (12 bits, drives `bank_timing`). Unused upper bits read 0.
- R9: Register 0x80 reads the size code (64 KiB→0, 128 KiB→1, 256 KiB→2, 512 KiB→3) and is read-only. With the default of 256 KiB it reads 2.
- R10: An address with bits 1:0 nonzero is not written and reads 0. An unmapped word address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Byte address |
| csr_wen | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from `csr_addr` |
| evt_pulse | input | 11 | Event inputs, one per status bit |
| err_addr | input | 18 | Failing address for the record |
| err_data | input | 128 | Failing data word for the record |
| err_syn | input | 16 | Syndrome for the record |
| irq | output | 1 | Level interrupt |
| err_resp_ctl | output | 4 | Error response control bits |
| ecc_mode | output | 3 | ECC enable, detect-only, inject |
| inj_data | output | 128 | Fault-injection data |
| inj_syn | output | 16 | Fault-injection syndrome |
| bank_timing | output | 12 | Four 3-bit bank timing fields |

## Verification
The assertions assume that `evt_pulse`, `csr_wen` and `csr_addr` are stable across each rising edge and that the error-report inputs are valid in any cycle where bit 6 or bit 7 pulses. The stimulus changes every input only on the falling edge, so both conditions hold. Events are held for one cycle, except in the saturation run, where bit 6 is held high for longer than the counter range. The one cycle where an event and a status clear land together is built on purpose, so that the event-wins rule is exercised.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
    localparam int DW       = 32;
    localparam int NSRC     = 11;
    localparam int FADDR_W  = 18;
    localparam int SYN_W    = 16;
    localparam int NWORDS   = 4;
    localparam int REC_W    = NWORDS * DW;
    localparam int NBANK    = 4;
    localparam int BANK_W   = 3;
    localparam int CNT_W    = 16;
    localparam int SRC_CE   = 6;
    localparam int SRC_UE   = 7;

    localparam logic [11:0] OFF_RESP   = 12'h000;
    localparam logic [11:0] OFF_STAT   = 12'h004;
    localparam logic [11:0] OFF_MASK   = 12'h008;
    localparam logic [11:0] OFF_ENA    = 12'h00C;
    localparam logic [11:0] OFF_DIS    = 12'h010;
    localparam logic [11:0] OFF_MODE   = 12'h014;
    localparam logic [11:0] OFF_CE_A   = 12'h01C;
    localparam logic [11:0] OFF_CE_D   = 12'h020;
    localparam logic [11:0] OFF_CE_S   = 12'h030;
    localparam logic [11:0] OFF_UE_A   = 12'h034;
    localparam logic [11:0] OFF_UE_D   = 12'h038;
    localparam logic [11:0] OFF_UE_S   = 12'h048;
    localparam logic [11:0] OFF_INJ_D  = 12'h04C;
    localparam logic [11:0] OFF_INJ_S  = 12'h05C;
    localparam logic [11:0] OFF_TIM    = 12'h060;
    localparam logic [11:0] OFF_CNT    = 12'h06C;
    localparam logic [11:0] OFF_SIZE   = 12'h080;

    function automatic logic [3:0] size_code(input int kib);
        case (kib)
            64:      return 4'd0;
            128:     return 4'd1;
            256:     return 4'd2;
            512:     return 4'd3;
            default: return 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/ecc_csr_irq.sv
module ecc_csr_irq #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic         ena_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] st;
        logic [N-1:0] mk;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_wr) s_d.st = s_d.st & ~wdata;
        s_d.st = s_d.st | evt;
        if (ena_wr) s_d.mk = s_d.mk | wdata;
        if (dis_wr) s_d.mk = s_d.mk & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= '0;
            s_q.mk <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status = s_q.st;
    assign mask   = s_q.mk;
    assign irq    = |(s_q.st & s_q.mk);

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
    p_no_bus_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((status & ~$past(status)) == '0));
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_wr && !dis_wr) |=> $stable(mask));
endmodule

// File: rtl/ecc_csr_capture.sv
module ecc_csr_capture #(
    parameter int AW = 18,
    parameter int RW = 128,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          held,
    input  logic [AW-1:0] in_addr,
    input  logic [RW-1:0] in_data,
    input  logic [SW-1:0] in_syn,
    output logic [AW-1:0] rec_addr,
    output logic [RW-1:0] rec_data,
    output logic [SW-1:0] rec_syn
);
    typedef struct packed {
        logic [AW-1:0] a;
        logic [RW-1:0] d;
        logic [SW-1:0] s;
    } rec_t;

    rec_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hit && !held) begin
            r_d.a = in_addr;
            r_d.d = in_data;
            r_d.s = in_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rec_addr = r_q.a;
    assign rec_data = r_q.d;
    assign rec_syn  = r_q.s;

    p_rec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(rec_addr) && $stable(rec_data) && $stable(rec_syn)));
    p_rec_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !held) |=> (rec_addr == $past(in_addr) && rec_syn == $past(in_syn)));
endmodule

// File: rtl/ecc_sram_csr.sv
module ecc_sram_csr
    import ecc_csr_pkg::*;
#(
    parameter int MEM_KIB = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          csr_addr,
    input  logic                 csr_wen,
    input  logic [DW-1:0]        csr_wdata,
    output logic [DW-1:0]        csr_rdata,
    input  logic [NSRC-1:0]      evt_pulse,
    input  logic [FADDR_W-1:0]   err_addr,
    input  logic [REC_W-1:0]     err_data,
    input  logic [SYN_W-1:0]     err_syn,
    output logic                 irq,
    output logic [3:0]           err_resp_ctl,
    output logic [2:0]           ecc_mode,
    output logic [REC_W-1:0]     inj_data,
    output logic [SYN_W-1:0]     inj_syn,
    output logic [NBANK*BANK_W-1:0] bank_timing
);
    localparam int TIM_W = NBANK * BANK_W;
    localparam logic [3:0] SIZE_CODE = size_code(MEM_KIB);
    localparam logic [TIM_W-1:0] TIM_RST = {NBANK{BANK_W'(1)}};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [3:0]       resp;
        logic [2:0]       mode;
        logic [REC_W-1:0] inj;
        logic [SYN_W-1:0] isyn;
        logic [TIM_W-1:0] tim;
        logic [CNT_W-1:0] cnt;
    } csr_t;

    csr_t c_d, c_q;

    logic word_ok, wr;
    assign word_ok = (csr_addr[1:0] == 2'b00);
    assign wr      = csr_wen && word_ok;

    logic [NSRC-1:0] status, mask;
    logic [1:0] cap_hit, cap_held;
    logic [FADDR_W-1:0] cap_a [2];
    logic [REC_W-1:0]   cap_d [2];
    logic [SYN_W-1:0]   cap_s [2];

    ecc_csr_irq #(.N(NSRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .clr_wr (wr && csr_addr == OFF_STAT),
        .ena_wr (wr && csr_addr == OFF_ENA),
        .dis_wr (wr && csr_addr == OFF_DIS),
        .wdata  (csr_wdata[NSRC-1:0]),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    for (genvar g = 0; g < 2; g++) begin : g_rec
        localparam int SRC = (g == 0) ? SRC_CE : SRC_UE;
        assign cap_hit[g]  = evt_pulse[SRC];
        assign cap_held[g] = status[SRC];
        ecc_csr_capture #(.AW(FADDR_W), .RW(REC_W), .SW(SYN_W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (cap_hit[g]),
            .held     (cap_held[g]),
            .in_addr  (err_addr),
            .in_data  (err_data),
            .in_syn   (err_syn),
            .rec_addr (cap_a[g]),
            .rec_data (cap_d[g]),
            .rec_syn  (cap_s[g])
        );
    end

    always_comb begin
        c_d = c_q;
        if (wr) begin
            if (csr_addr == OFF_RESP)  c_d.resp = csr_wdata[3:0];
            if (csr_addr == OFF_MODE)  c_d.mode = csr_wdata[2:0];
            if (csr_addr == OFF_INJ_S) c_d.isyn = csr_wdata[SYN_W-1:0];
            if (csr_addr == OFF_TIM)   c_d.tim  = csr_wdata[TIM_W-1:0];
            if (csr_addr == OFF_CNT)   c_d.cnt  = c_q.cnt & ~csr_wdata[CNT_W-1:0];
            for (int k = 0; k < NWORDS; k++) begin
                if (csr_addr == OFF_INJ_D + 12'(4 * k)) c_d.inj[k*DW +: DW] = csr_wdata;
            end
        end
        if (evt_pulse[SRC_CE] && c_d.cnt != CNT_MAX) c_d.cnt = c_d.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.tim <= TIM_RST;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (word_ok) begin
            case (csr_addr)
                OFF_RESP:  csr_rdata = DW'(c_q.resp);
                OFF_STAT:  csr_rdata = DW'(status);
                OFF_MASK:  csr_rdata = DW'(mask);
                OFF_MODE:  csr_rdata = DW'(c_q.mode);
                OFF_CE_A:  csr_rdata = DW'(cap_a[0]);
                OFF_CE_S:  csr_rdata = DW'(cap_s[0]);
                OFF_UE_A:  csr_rdata = DW'(cap_a[1]);
                OFF_UE_S:  csr_rdata = DW'(cap_s[1]);
                OFF_INJ_S: csr_rdata = DW'(c_q.isyn);
                OFF_TIM:   csr_rdata = DW'(c_q.tim);
                OFF_CNT:   csr_rdata = DW'(c_q.cnt);
                OFF_SIZE:  csr_rdata = DW'(SIZE_CODE);
                default:   csr_rdata = '0;
            endcase
            for (int k = 0; k < NWORDS; k++) begin
                if (csr_addr == OFF_CE_D + 12'(4 * k))  csr_rdata = cap_d[0][k*DW +: DW];
                if (csr_addr == OFF_UE_D + 12'(4 * k))  csr_rdata = cap_d[1][k*DW +: DW];
                if (csr_addr == OFF_INJ_D + 12'(4 * k)) csr_rdata = c_q.inj[k*DW +: DW];
            end
        end
    end

    assign err_resp_ctl = c_q.resp;
    assign ecc_mode     = c_q.mode;
    assign inj_data     = c_q.inj;
    assign inj_syn      = c_q.isyn;
    assign bank_timing  = c_q.tim;

    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(status & mask)));
    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt == CNT_MAX && !(wr && csr_addr == OFF_CNT)) |=> (c_q.cnt == CNT_MAX));
    p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pulse[SRC_CE] && !(wr && csr_addr == OFF_CNT)) |=> $stable(c_q.cnt));
    p_misaligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr[1:0] != 2'b00) |-> (csr_rdata == '0));
endmodule

// File: tb/ecc_sram_csr_bench.sv
`timescale 1ns/1ps
module ecc_sram_csr_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [11:0]  csr_addr = '0;
    logic         csr_wen = 0;
    logic [31:0]  csr_wdata = '0;
    logic [31:0]  csr_rdata;
    logic [10:0]  evt_pulse = '0;
    logic [17:0]  err_addr = '0;
    logic [127:0] err_data = '0;
    logic [15:0]  err_syn = '0;
    logic         irq;
    logic [3:0]   err_resp_ctl;
    logic [2:0]   ecc_mode;
    logic [127:0] inj_data;
    logic [15:0]  inj_syn;
    logic [11:0]  bank_timing;

    int checks = 0, errors = 0;
    bit done = 0;
    int cnt_exp = 0;

    always #4 clk = ~clk;

    ecc_sram_csr u_ecc_sram_csr (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wen = 1;
        @(negedge clk);
        csr_wen = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic pulse(input logic [10:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa, pb;
        pa = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        pb = 128'hA5A5_0001_5A5A_0002_DEAD_BEEF_CAFE_F00D;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 and R9: reset state
        rd_chk("R1 status", 12'h004, 32'h0);
        rd_chk("R1 mask", 12'h008, 32'h7FF);
        rd_chk("R1 timing", 12'h060, 32'h249);
        check("R1 timing port", 32'(bank_timing), 32'h249);
        check("R1 irq", 32'(irq), 32'h0);
        rd_chk("R1 mode", 12'h014, 32'h0);
        rd_chk("R1 counter", 12'h06C, 32'h0);
        rd_chk("R9 size", 12'h080, 32'h2);

        // R6: first corrected error captured
        err_addr = 18'h2_3456; err_data = pa; err_syn = 16'hBEEF;
        pulse(11'h040); cnt_exp++;
        rd_chk("R6 ce addr", 12'h01C, 32'h2_3456);
        for (int k = 0; k < 4; k++) rd_chk("R6 ce data", 12'h020 + 12'(4*k), pa[32*k +: 32]);
        rd_chk("R6 ce syn", 12'h030, 32'hBEEF);
        err_addr = 18'h1_1111; err_data = pb; err_syn = 16'h1234;
        pulse(11'h040); cnt_exp++;
        rd_chk("R6 ce held addr", 12'h01C, 32'h2_3456);
        rd_chk("R6 ce held data", 12'h02C, pa[127:96]);
        pulse(11'h080);
        rd_chk("R6 ue addr", 12'h034, 32'h1_1111);
        for (int k = 0; k < 4; k++) rd_chk("R6 ue data", 12'h038 + 12'(4*k), pb[32*k +: 32]);
        rd_chk("R6 ue syn", 12'h048, 32'h1234);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd_chk("R6 ce read-only", 12'h01C, 32'h2_3456);
        wr(12'h004, 32'h0C0);
        rd_chk("R3 status cleared", 12'h004, 32'h0);
        pulse(11'h040); cnt_exp++;
        rd_chk("R6 ce reload", 12'h01C, 32'h1_1111);
        rd_chk("R7 counter", 12'h06C, 32'(cnt_exp));
        wr(12'h004, 32'h7FF);

        // R2, R3, R5: per-bit sweep
        for (int i = 0; i < 11; i++) begin
            wr(12'h004, 32'h7FF);
            rd_chk("R2 bus cannot set", 12'h004, 32'h0);
            pulse(11'(1 << i));
            if (i == 6) cnt_exp++;
            rd_chk("R2 event sets", 12'h004, 32'(1 << i));
            check("R5 irq on", 32'(irq), 32'h1);
            wr(12'h004, 32'h0);
            rd_chk("R3 zero keeps", 12'h004, 32'(1 << i));
            wr(12'h004, 32'hFFFF_F800 | 32'(1 << i));
            rd_chk("R3 w1c", 12'h004, 32'h0);
            check("R5 irq off", 32'(irq), 32'h0);
        end

        // R2: event and clear in the same cycle
        @(negedge clk);
        evt_pulse = 11'h008; csr_addr = 12'h004; csr_wdata = 32'h008; csr_wen = 1;
        @(negedge clk);
        evt_pulse = '0; csr_wen = 0;
        rd_chk("R2 event wins", 12'h004, 32'h008);

        // R4, R5: mask via enable/disable
        wr(12'h010, 32'h7FF);
        rd_chk("R4 disable all", 12'h008, 32'h0);
        check("R5 masked", 32'(irq), 32'h0);
        wr(12'h008, 32'h7FF);
        rd_chk("R4 mask read-only", 12'h008, 32'h0);
        rd_chk("R4 enable reads 0", 12'h00C, 32'h0);
        rd_chk("R4 disable reads 0", 12'h010, 32'h0);
        wr(12'h00C, 32'h008);
        wr(12'h00C, 32'h100);
        rd_chk("R4 enable ors", 12'h008, 32'h108);
        check("R5 unmasked", 32'(irq), 32'h1);
        wr(12'h010, 32'h008);
        rd_chk("R4 disable clears", 12'h008, 32'h100);
        check("R5 masked again", 32'(irq), 32'h0);
        for (int i = 0; i < 11; i++) begin
            wr(12'h010, 32'h7FF);
            wr(12'h00C, 32'(1 << i));
            check("R5 mask sweep", 32'(irq), (i == 3) ? 32'h1 : 32'h0);
        end
        wr(12'h00C, 32'h7FF);
        wr(12'h004, 32'h7FF);

        // R7: counter clear and saturation
        rd_chk("R7 count", 12'h06C, 32'(cnt_exp));
        wr(12'h06C, 32'(cnt_exp));
        rd_chk("R7 w1c", 12'h06C, 32'h0);
        @(negedge clk);
        evt_pulse = 11'h040;
        repeat (70000) @(negedge clk);
        evt_pulse = '0;
        rd_chk("R7 saturate", 12'h06C, 32'hFFFF);
        wr(12'h06C, 32'h0001);
        rd_chk("R7 partial clear", 12'h06C, 32'hFFFE);
        wr(12'h004, 32'h7FF);

        // R8: read/write registers
        wr(12'h000, 32'hFFFF_FFFF);
        rd_chk("R8 resp", 12'h000, 32'hF);
        check("R8 resp port", 32'(err_resp_ctl), 32'hF);
        wr(12'h014, 32'hFFFF_FFFF);
        rd_chk("R8 mode", 12'h014, 32'h7);
        wr(12'h014, 32'h5);
        check("R8 mode port", 32'(ecc_mode), 32'h5);
        for (int k = 0; k < 4; k++) wr(12'h04C + 12'(4*k), pb[32*k +: 32]);
        for (int k = 0; k < 4; k++) rd_chk("R8 inj data", 12'h04C + 12'(4*k), pb[32*k +: 32]);
        check("R8 inj port", inj_data[95:64], pb[95:64]);
        wr(12'h05C, 32'hFFFF_FFFF);
        rd_chk("R8 inj syn", 12'h05C, 32'hFFFF);
        check("R8 inj syn port", 32'(inj_syn), 32'hFFFF);
        wr(12'h060, 32'hFFFF_FFFF);
        rd_chk("R8 timing", 12'h060, 32'hFFF);

        // R10, R9: misaligned, unmapped, read-only size
        wr(12'h061, 32'h0);
        rd_chk("R10 misaligned write ignored", 12'h060, 32'hFFF);
        rd_chk("R10 misaligned read", 12'h061, 32'h0);
        rd_chk("R10 unmapped", 12'h100, 32'h0);
        wr(12'h080, 32'h0);
        rd_chk("R9 size read-only", 12'h080, 32'h2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule